// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block recovers characters from a single serial input that carries no clock. The line rests high when idle. A character opens with one low start bit, continues with the data bits least significant first, and closes with a high stop period. A free-running divider turns the system clock into a sample tick at sixteen times the bit rate. The receiver aligns its bit timing to the high-to-low transition that begins each start bit. It then decides every bit by majority vote over seven samples taken around the bit centre. Because of this vote, a short disturbance on the line does not corrupt a character. Transmitters whose bit rate differs by about three percent are still received correctly.

Each completed character appears on a parallel output together with a one-cycle valid strobe. A framing flag is raised with the strobe when the stop bit is received low. Two mode inputs select the character format, and both are captured when a start edge is accepted. One mode input selects 5 or 8 data bits. The other selects one or one-and-a-half stop bits. The line passes through a two-stage synchronizer before any sampling takes place.

Top module: `osr_serial_rx`

## Requirements
- R1: While reset is asserted and afterwards until the first character completes, rxValid and frameErr are 0 and rxData is all zeros.
- R2: A line that stays high produces no output. The only event that can begin a character is a high-to-low change between two consecutive sample ticks.
- R3: The start bit is sampled again at sample index 7 of 16. If the line is high there, the receiver returns to idle and produces no output. A low pulse that lasts past that point is received as a character.
- R4: Each bit takes the level seen in at least 4 of the 7 samples with indices 5 to 11 of its 16. A disturbance that covers at most 3 of those samples does not change the bit. A disturbance that covers 4 or more samples does change it.
- R5: With shortWord=0 the first data bit after the start bit lands in rxData[0] and the eighth data bit in rxData[7]. rxData changes only in the cycle where rxValid is 1.
- R6: With shortWord=1, five data bits are received into rxData[4:0], and rxData[7:5] read 0 with each strobe.
- R7: rxValid is a one-cycle pulse, one per received character. frameErr is 1 exactly when the stop bit is voted low, and it is never 1 without rxValid.
- R8: With halfStop=0 the receiver accepts a new start edge once 12 samples of the stop bit have passed. With halfStop=1 it ignores the line until 20 samples of the stop period have passed. So a start bit that follows a single stop bit without a gap is lost in that mode.
- R9: Characters sent at a bit period 3 percent shorter or longer than nominal are received without error in both word lengths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxLine | input | 1 | Serial line, idle high, asynchronous to clk |
| shortWord | input | 1 | 1 selects 5 data bits, 0 selects 8 |
| halfStop | input | 1 | 1 selects one-and-a-half stop bits, 0 selects one |
| rxData | output | DATA_W | Last received character, first bit in bit 0 |
| rxValid | output | 1 | One-cycle strobe for a new character |
| frameErr | output | 1 | Stop bit was low; only asserted with rxValid |

## Verification
The hardest cases to reach are the ones that depend on where the samples fall inside a bit. The receiver's sample phase is only known to within one tick, because the divider runs freely and the synchronizer adds its own delay. Disturbances for the vote checks are therefore sized in whole clock cycles. A 12-cycle pulse can cover at most three sample instants, and a 20-cycle pulse placed at 26 cycles into the bit is sure to cover five samples inside the vote window, for any phase. The stop-length lockout is reached by sending two characters with no idle gap. The second start edge then arrives 16 samples into the stop period, which falls between the two release points, so the outcome shows which mode is active.

// File: rtl/osr_rx_pkg.sv
package osr_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rxState_e;

  // strobes from the control FSM to the datapath, all qualified by the sample tick
  typedef struct packed {
    logic accClr;    // restart the vote accumulator
    logic accEn;     // add the current sample to the accumulator
    logic dataClr;   // clear the character register at a new start
    logic bitStore;  // write the voted bit at the current bit index
    logic charEmit;  // present the character and the stop-bit verdict
  } rxStrobe_t;

endpackage

// File: rtl/osr_rx_tick.sv
module osr_rx_tick #(
  parameter int CLK_DIV = 68
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);
  localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(CLK_DIV - 1);

  logic [CNT_W-1:0] divCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (divCnt == CNT_END) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign tick = (divCnt == CNT_END);

endmodule

// File: rtl/osr_rx_dpath.sv
module osr_rx_dpath
  import osr_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int VOTE_CNT    = 7
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      rxLine,
  input  logic                      tick,
  input  rxStrobe_t                 strobe,
  input  logic [$clog2(DATA_W)-1:0] bitIdx,
  output logic                      lineNow,
  output logic                      fallEdge,
  output logic                      bitVal,
  output logic [DATA_W-1:0]         rxData,
  output logic                      rxValid,
  output logic                      frameErr
);
  localparam int ACC_W     = $clog2(VOTE_CNT + 1);
  localparam int VOTE_NEED = VOTE_CNT / 2 + 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lineLast;
  logic [ACC_W-1:0]       ones;
  logic [ACC_W:0]         voteSum;
  logic [DATA_W-1:0]      dataReg;

  // synchronizer depth chosen by parameter
  if (SYNC_STAGES == 1) begin : g_sync_single
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ <= 1'b1;
      else       syncQ <= rxLine;
    end
  end else begin : g_sync_chain
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ <= '1;
      else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxLine};
    end
  end

  assign lineNow = syncQ[SYNC_STAGES-1];

  // previous sample, updated on every tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     lineLast <= 1'b1;
    else if (tick) lineLast <= lineNow;
  end

  assign fallEdge = lineLast & ~lineNow;

  // majority vote accumulator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ones <= '0;
    end else if (strobe.accClr) begin
      ones <= '0;
    end else if (strobe.accEn && lineNow) begin
      ones <= ones + 1'b1;
    end
  end

  assign voteSum = {1'b0, ones} + (ACC_W+1)'(lineNow);
  assign bitVal  = (voteSum >= (ACC_W+1)'(VOTE_NEED));

  // character assembly, first bit received into bit 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (strobe.dataClr) begin
      dataReg <= '0;
    end else if (strobe.bitStore) begin
      dataReg[bitIdx] <= bitVal;
    end
  end

  // output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData   <= '0;
      rxValid  <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      rxValid  <= strobe.charEmit;
      frameErr <= strobe.charEmit & ~bitVal;
      if (strobe.charEmit) rxData <= dataReg;
    end
  end

endmodule

// File: rtl/osr_rx_ctrl.sv
module osr_rx_ctrl
  import osr_rx_pkg::*;
#(
  parameter int OSR        = 16,
  parameter int DATA_W     = 8,
  parameter int SHORT_W    = 5,
  parameter int VOTE_FIRST = 5,
  parameter int VOTE_CNT   = 7
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      tick,
  input  logic                      lineNow,
  input  logic                      fallEdge,
  input  logic                      shortWord,
  input  logic                      halfStop,
  output rxStrobe_t                 strobe,
  output logic [$clog2(DATA_W)-1:0] bitIdx,
  output logic                      modeShort
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int CNT_W = $clog2(2 * OSR);
  localparam logic [CNT_W-1:0] HALF_IDX  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] VOTE_LO   = CNT_W'(VOTE_FIRST);
  localparam logic [CNT_W-1:0] VOTE_HI   = CNT_W'(VOTE_FIRST + VOTE_CNT - 1);
  localparam logic [CNT_W-1:0] LONG_END  = CNT_W'(OSR + OSR / 4 - 1);
  localparam logic [IDX_W-1:0] IDX_LONG  = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] IDX_SHORT = IDX_W'(SHORT_W - 1);

  rxState_e         state;
  logic [CNT_W-1:0] tickCnt;
  logic             modeHalf;
  logic             inWindow;
  logic             lastBit;
  logic             stopRelease;

  assign inWindow    = (tickCnt >= VOTE_LO) && (tickCnt <= VOTE_HI);
  assign lastBit     = (bitIdx == (modeShort ? IDX_SHORT : IDX_LONG));
  assign stopRelease = modeHalf ? (tickCnt == LONG_END) : (tickCnt == VOTE_HI);

  always_comb begin
    strobe          = '0;
    strobe.accClr   = tick && (((state == ST_IDLE) && fallEdge) ||
                               (((state == ST_START) || (state == ST_DATA)) && (tickCnt == LAST_IDX)));
    strobe.accEn    = tick && (state != ST_IDLE) && inWindow;
    strobe.dataClr  = tick && (state == ST_IDLE) && fallEdge;
    strobe.bitStore = tick && (state == ST_DATA) && (tickCnt == VOTE_HI);
    strobe.charEmit = tick && (state == ST_STOP) && (tickCnt == VOTE_HI);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      tickCnt   <= '0;
      bitIdx    <= '0;
      modeShort <= 1'b0;
      modeHalf  <= 1'b0;
    end else if (tick) begin
      unique case (state)
        ST_IDLE: begin
          if (fallEdge) begin
            state     <= ST_START;
            tickCnt   <= CNT_W'(1);
            modeShort <= shortWord;
            modeHalf  <= halfStop;
          end
        end
        ST_START: begin
          if ((tickCnt == HALF_IDX) && lineNow) begin
            state   <= ST_IDLE;
            tickCnt <= '0;
          end else if (tickCnt == LAST_IDX) begin
            state   <= ST_DATA;
            tickCnt <= '0;
            bitIdx  <= '0;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (tickCnt == LAST_IDX) begin
            tickCnt <= '0;
            if (lastBit) state  <= ST_STOP;
            else         bitIdx <= bitIdx + 1'b1;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (stopRelease) begin
            state   <= ST_IDLE;
            tickCnt <= '0;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/osr_serial_rx.sv
module osr_serial_rx
  import osr_rx_pkg::*;
#(
  parameter int CLK_DIV     = 68,
  parameter int OSR         = 16,
  parameter int DATA_W      = 8,
  parameter int SHORT_W     = 5,
  parameter int VOTE_FIRST  = 5,
  parameter int VOTE_CNT    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              shortWord,
  input  logic              halfStop,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              frameErr
);
  localparam int IDX_W = $clog2(DATA_W);

  logic             tick;
  logic             lineNow;
  logic             fallEdge;
  logic             bitVal;
  rxStrobe_t        strobe;
  logic [IDX_W-1:0] bitIdx;
  logic             curShort;

  osr_rx_tick #(.CLK_DIV(CLK_DIV)) tick_i (
    .clk  (clk),
    .rstN (rstN),
    .tick (tick)
  );

  osr_rx_ctrl #(
    .OSR(OSR), .DATA_W(DATA_W), .SHORT_W(SHORT_W),
    .VOTE_FIRST(VOTE_FIRST), .VOTE_CNT(VOTE_CNT)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .lineNow   (lineNow),
    .fallEdge  (fallEdge),
    .shortWord (shortWord),
    .halfStop  (halfStop),
    .strobe    (strobe),
    .bitIdx    (bitIdx),
    .modeShort (curShort)
  );

  osr_rx_dpath #(
    .SYNC_STAGES(SYNC_STAGES), .DATA_W(DATA_W), .VOTE_CNT(VOTE_CNT)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .rxLine   (rxLine),
    .tick     (tick),
    .strobe   (strobe),
    .bitIdx   (bitIdx),
    .lineNow  (lineNow),
    .fallEdge (fallEdge),
    .bitVal   (bitVal),
    .rxData   (rxData),
    .rxValid  (rxValid),
    .frameErr (frameErr)
  );

endmodule

// File: rtl/osr_serial_rx_chk.sv
module osr_serial_rx_chk #(
  parameter int DATA_W  = 8,
  parameter int SHORT_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxValid,
  input logic              frameErr,
  input logic [DATA_W-1:0] rxData,
  input logic              curShort
);

  // R1: outputs quiet in the cycle after reset is seen
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!rxValid && !frameErr));

  // R7: strobe lasts exactly one cycle
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R7: framing flag only with the strobe
  p_ferr_with_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> rxValid);

  // R6: short characters leave the upper bits clear
  p_short_upper_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && $past(curShort)) |-> (rxData[DATA_W-1:SHORT_W] == '0));

  // R5: character output holds between strobes
  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |-> $stable(rxData));

endmodule

bind osr_serial_rx osr_serial_rx_chk #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .rxValid  (rxValid),
  .frameErr (frameErr),
  .rxData   (rxData),
  .curShort (curShort)
);

// File: tb/osr_serial_rx_tb.sv
module osr_serial_rx_tb_top;
  localparam int DIV  = 4;
  localparam int OSR  = 16;
  localparam int BITC = DIV * OSR;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxLine = 1'b1;
  logic       shortWord = 1'b0;
  logic       halfStop = 1'b0;
  logic [7:0] rxData;
  logic       rxValid;
  logic       frameErr;

  always #4 clk = ~clk;

  osr_serial_rx #(.CLK_DIV(DIV)) dut_i (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .shortWord(shortWord),
    .halfStop(halfStop), .rxData(rxData), .rxValid(rxValid), .frameErr(frameErr)
  );

  typedef struct {
    logic [7:0] data;
    logic       ferr;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int  nChecks = 0;
  int  nFails = 0;
  int  gotCount = 0;
  bit  done = 1'b0;
  logic prevValid = 1'b0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: compare every strobe against the scoreboard
  always @(negedge clk) begin
    expItem_t e;
    if (rstN && rxValid) begin
      gotCount++;
      check(!prevValid, "R7", "strobe longer than one cycle", 1, 0);
      if (expQ.size() == 0) begin
        check(1'b0, "R2", "unexpected character", int'(rxData), 0);
      end else begin
        e = expQ.pop_front();
        check(rxData == e.data, e.tag, "data", int'(rxData), int'(e.data));
        check(frameErr == e.ferr, e.tag, "frame flag", int'(frameErr), int'(e.ferr));
      end
    end
    prevValid = rxValid;
  end

  task automatic driveBit(input logic lvl, input int clks, input int gAt, input int gLen);
    for (int i = 0; i < clks; i++) begin
      @(negedge clk);
      rxLine = (i >= gAt && i < gAt + gLen) ? ~lvl : lvl;
    end
  endtask

  task automatic idle(input int clks);
    driveBit(1'b1, clks, 0, 0);
  endtask

  // gBit: 0 = start bit, 1..nb = data bits, nb+1 = stop bit
  task automatic sendFrame(input logic [7:0] d, input int nb, input int bitClks, input int stopClks,
                           input logic stopLvl, input int gBit, input int gAt, input int gLen);
    driveBit(1'b0, bitClks, (gBit == 0) ? gAt : 0, (gBit == 0) ? gLen : 0);
    for (int b = 0; b < nb; b++)
      driveBit(d[b], bitClks, (gBit == b + 1) ? gAt : 0, (gBit == b + 1) ? gLen : 0);
    driveBit(stopLvl, stopClks, (gBit == nb + 1) ? gAt : 0, (gBit == nb + 1) ? gLen : 0);
  endtask

  task automatic expectChar(input logic [7:0] d, input logic f, input string tag);
    expItem_t e;
    e.data = d;
    e.ferr = f;
    e.tag  = tag;
    expQ.push_back(e);
  endtask

  task automatic sendChar(input logic [7:0] d, input int nb, input int bitClks, input int stopClks, input string tag);
    logic [7:0] mask;
    mask = (nb >= 8) ? 8'hFF : 8'((1 << nb) - 1);
    expectChar(d & mask, 1'b0, tag);
    sendFrame(d, nb, bitClks, stopClks, 1'b1, -1, 0, 0);
    idle(2 * BITC);
  endtask

  task automatic drain(input string tag);
    idle(3 * BITC);
    check(expQ.size() == 0, tag, "characters still pending", expQ.size(), 0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  initial begin
    int g0;
    repeat (5) @(negedge clk);
    // R1: reset state
    check(rxValid == 1'b0, "R1", "rxValid in reset", int'(rxValid), 0);
    check(frameErr == 1'b0, "R1", "frameErr in reset", int'(frameErr), 0);
    check(rxData == 8'h00, "R1", "rxData in reset", int'(rxData), 0);
    rstN = 1'b1;
    idle(BITC);
    check(rxData == 8'h00 && !rxValid, "R1", "outputs after reset release", int'(rxData), 0);

    // R2: steady high line stays silent
    g0 = gotCount;
    idle(20 * BITC);
    check(gotCount == g0, "R2", "characters on idle line", gotCount - g0, 0);

    // R5: eight-bit characters, first bit into bit 0
    shortWord = 1'b0; halfStop = 1'b0;
    sendChar(8'hA5, 8, BITC, BITC, "R5");
    sendChar(8'h01, 8, BITC, BITC, "R5");
    sendChar(8'h80, 8, BITC, BITC, "R5");
    sendChar(8'h00, 8, BITC, BITC, "R5");
    sendChar(8'hFF, 8, BITC, BITC, "R5");
    drain("R5");

    // R3: short low pulse rejected at the start re-check
    g0 = gotCount;
    driveBit(1'b0, 20, 0, 0);
    idle(4 * BITC);
    check(gotCount == g0, "R3", "characters from short pulse", gotCount - g0, 0);
    // R3: a pulse past the half-bit point is taken as a start, all-ones data follows
    expectChar(8'hFF, 1'b0, "R3");
    driveBit(1'b0, 40, 0, 0);
    idle(12 * BITC);
    drain("R3");

    // R4: three-sample disturbance outvoted
    expectChar(8'h5A, 1'b0, "R4");
    sendFrame(8'h5A, 8, BITC, BITC, 1'b1, 4, 24, 12);
    idle(2 * BITC);
    // R4: five-sample disturbance inside the window wins the vote (data bit 2 flips)
    expectChar(8'hFB, 1'b0, "R4");
    sendFrame(8'hFF, 8, BITC, BITC, 1'b1, 3, 26, 20);
    idle(2 * BITC);
    // R4: low disturbance in the stop bit does not raise the framing flag
    expectChar(8'h96, 1'b0, "R4");
    sendFrame(8'h96, 8, BITC, BITC, 1'b1, 9, 24, 12);
    idle(2 * BITC);
    drain("R4");

    // R6: five-bit characters with one-and-a-half stop bits
    shortWord = 1'b1; halfStop = 1'b1;
    sendChar(8'h15, 5, BITC, BITC * 3 / 2, "R6");
    sendChar(8'h0A, 5, BITC, BITC * 3 / 2, "R6");
    sendChar(8'h1F, 5, BITC, BITC * 3 / 2, "R6");
    sendChar(8'hE6, 5, BITC, BITC * 3 / 2, "R6");
    drain("R6");

    // R7: low stop bit flags a framing error, next character is clean
    shortWord = 1'b0; halfStop = 1'b0;
    expectChar(8'h33, 1'b1, "R7");
    sendFrame(8'h33, 8, BITC, BITC, 1'b0, -1, 0, 0);
    idle(2 * BITC);
    sendChar(8'h44, 8, BITC, BITC, "R7");
    drain("R7");

    // R8: back-to-back frames with one stop bit, single-stop mode receives both
    shortWord = 1'b1; halfStop = 1'b0;
    expectChar(8'h0B, 1'b0, "R8");
    expectChar(8'h00, 1'b0, "R8");
    sendFrame(8'h0B, 5, BITC, BITC, 1'b1, -1, 0, 0);
    sendFrame(8'h00, 5, BITC, BITC, 1'b1, -1, 0, 0);
    idle(2 * BITC);
    drain("R8");
    // R8: same stream in long-stop mode loses the second character
    halfStop = 1'b1;
    g0 = gotCount;
    expectChar(8'h0B, 1'b0, "R8");
    sendFrame(8'h0B, 5, BITC, BITC, 1'b1, -1, 0, 0);
    sendFrame(8'h00, 5, BITC, BITC, 1'b1, -1, 0, 0);
    idle(2 * BITC);
    drain("R8");
    check(gotCount == g0 + 1, "R8", "characters in long-stop mode", gotCount - g0, 1);

    // R9: bit period off by about three percent either way
    shortWord = 1'b0; halfStop = 1'b0;
    sendChar(8'hC3, 8, BITC - 2, BITC - 2, "R9");
    sendChar(8'h3C, 8, BITC + 2, BITC + 2, "R9");
    sendChar(8'h81, 8, BITC - 2, BITC - 2, "R9");
    sendChar(8'h7E, 8, BITC + 2, BITC + 2, "R9");
    shortWord = 1'b1;
    sendChar(8'h13, 5, BITC + 2, BITC + 2, "R9");
    sendChar(8'h0C, 5, BITC - 2, BITC - 2, "R9");
    drain("R9");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL all requirements watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule